// File: doc/BRIEF.md
# CEC Receive Error-Bit Policy Unit

This unit works next to a CEC bit receiver that measures the line waveform. The receiver raises one-cycle strobes when it sees a rising edge at the wrong time, a bit period that is too short, or one that is too long. It also raises strobes for a missing acknowledge and for a receive overrun. The policy unit decides what happens next. It can stop the reception, and it can ask the bus driver to send an error bit, which is a low level held for about 1.5 bit periods. It also records every error in a sticky flag that is cleared by writing one.

Five configuration inputs set the policy:
- stop reception on a rising error;
- send an error bit on a rising error;
- send an error bit on a long period;
- stay quiet on broadcast frames;
- full listen.

Broadcast frames follow their own rule. That rule replaces the two per-error enables. It can request an error bit even when those enables are off, unless the quiet setting is on. In full listen mode, a short period inside a broadcast frame never requests an error bit.

Top module: `cec_rx_err_policy`

## Requirements
- R1: After a synchronous reset, rx_stop_o, errbit_req_o and all flags_o bits are 0.
- R2: rx_stop_o pulses exactly when err_rise_i was high with cfg_stop_rise_i set in the previous cycle. The broadcast setting and the frame type have no effect on it.
- R3: On a non-broadcast frame, a rising error requests an error bit only when both cfg_gen_rise_i and cfg_stop_rise_i are set.
- R4: On a non-broadcast frame, a long-period error requests an error bit exactly when cfg_gen_long_i is set.
- R5: On a non-broadcast frame, a short-period error always requests an error bit.
- R6: On a broadcast frame with cfg_bcast_quiet_i clear, a rising error requests an error bit exactly when cfg_stop_rise_i is set, whatever the value of cfg_gen_rise_i.
- R7: On a broadcast frame with cfg_bcast_quiet_i clear, a long-period error always requests an error bit, whatever the value of cfg_gen_long_i.
- R8: On a broadcast frame with cfg_bcast_quiet_i set, rising and long-period errors never request an error bit.
- R9: On a broadcast frame, a short-period error requests an error bit exactly when cfg_full_listen_i is clear.
- R10: Each error strobe sets its own sticky bit in flags_o. The bit positions are: 0 rising, 1 short period, 2 long period, 3 missing acknowledge, 4 overrun.
- R11: A 1 in flag_clr_i[k] clears flags_o[k] on the next cycle. If error k is strobed in the same cycle, the flag stays set.
- R12: rx_stop_o and errbit_req_o are registered single-cycle pulses that appear one cycle after the strobe. Errors that arrive in the same cycle produce one combined request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_rise_i | input | 1 | Bit-rising error strobe |
| err_short_i | input | 1 | Short bit period error strobe |
| err_long_i | input | 1 | Long bit period error strobe |
| err_noack_i | input | 1 | Missing acknowledge strobe |
| err_ovr_i | input | 1 | Receive overrun strobe |
| frame_bcast_i | input | 1 | Current frame is a broadcast frame |
| cfg_stop_rise_i | input | 1 | Stop reception on a rising error |
| cfg_gen_rise_i | input | 1 | Error bit on a rising error (non-broadcast frames) |
| cfg_gen_long_i | input | 1 | Error bit on a long period (non-broadcast frames) |
| cfg_bcast_quiet_i | input | 1 | Suppress broadcast error bits for rising and long-period errors |
| cfg_full_listen_i | input | 1 | Full listen mode |
| flag_clr_i | input | 5 | Write-one-to-clear mask for the flags |
| rx_stop_o | output | 1 | Stop-reception pulse |
| errbit_req_o | output | 1 | Error-bit drive request pulse |
| flags_o | output | 5 | Sticky error flags |

## Verification
The hardest cases to reach are the broadcast rules. In these cases a per-error enable that is off must still produce an error bit, or one that is on must be overridden. They only show up for particular combinations of five configuration bits, the frame type and the error mix. The stimulus therefore sweeps every combination of the five configuration bits, the broadcast bit and the three timing-error strobes, 512 vectors in all. Each vector checks both the pulse and its return to zero. A separate sequence makes a flag set and a flag clear collide in the same cycle for every flag position.

// File: rtl/cec_err_pkg.sv
package cec_err_pkg;

    localparam int NUM_ERR = 5;

    typedef enum int unsigned {
        E_RISE  = 0,
        E_SHORT = 1,
        E_LONG  = 2,
        E_NOACK = 3,
        E_OVR   = 4
    } err_idx_e;

    typedef struct packed {
        logic stop_on_rise;
        logic gen_on_rise;
        logic gen_on_long;
        logic bcast_quiet;
        logic full_listen;
    } policy_cfg_t;

    typedef struct packed {
        logic rise;
        logic short_p;
        logic long_p;
    } timing_err_t;

    // Per-error permission to drive an error bit. Broadcast frames use
    // their own rule, which replaces the per-error enables.
    function automatic logic wants_errbit(timing_err_t e, logic bcast, policy_cfg_t c);
        logic ok_rise, ok_short, ok_long;
        if (!bcast) begin
            ok_rise  = c.gen_on_rise & c.stop_on_rise;
            ok_long  = c.gen_on_long;
            ok_short = 1'b1;
        end else begin
            ok_rise  = ~c.bcast_quiet & c.stop_on_rise;
            ok_long  = ~c.bcast_quiet;
            ok_short = ~c.full_listen;
        end
        return (e.rise & ok_rise) | (e.short_p & ok_short) | (e.long_p & ok_long);
    endfunction

endpackage

// File: rtl/cec_err_decide.sv
module cec_err_decide
    import cec_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  timing_err_t terr,
    input  logic        bcast,
    input  policy_cfg_t cfg,
    output logic        stop_o,
    output logic        errbit_o
);
    logic stop_q, errbit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q   <= 1'b0;
            errbit_q <= 1'b0;
        end else begin
            stop_q   <= terr.rise & cfg.stop_on_rise;
            errbit_q <= wants_errbit(terr, bcast, cfg);
        end
    end

    assign stop_o   = stop_q;
    assign errbit_o = errbit_q;
endmodule

// File: rtl/cec_err_flags.sv
module cec_err_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] q;

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= 1'b0;
            else if (set_i[i]) q[i] <= 1'b1;   // a new error beats a clear
            else if (clr_i[i]) q[i] <= 1'b0;
        end
    end

    assign flags_o = q;
endmodule

// File: rtl/cec_rx_err_policy.sv
module cec_rx_err_policy
    import cec_err_pkg::*;
#(
    parameter int NFLAG = cec_err_pkg::NUM_ERR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_rise_i,
    input  logic             err_short_i,
    input  logic             err_long_i,
    input  logic             err_noack_i,
    input  logic             err_ovr_i,
    input  logic             frame_bcast_i,
    input  logic             cfg_stop_rise_i,
    input  logic             cfg_gen_rise_i,
    input  logic             cfg_gen_long_i,
    input  logic             cfg_bcast_quiet_i,
    input  logic             cfg_full_listen_i,
    input  logic [NFLAG-1:0] flag_clr_i,
    output logic             rx_stop_o,
    output logic             errbit_req_o,
    output logic [NFLAG-1:0] flags_o
);
    policy_cfg_t      cfg;
    timing_err_t      terr;
    logic [NFLAG-1:0] set_vec;

    assign cfg = '{stop_on_rise: cfg_stop_rise_i, gen_on_rise: cfg_gen_rise_i,
                   gen_on_long: cfg_gen_long_i, bcast_quiet: cfg_bcast_quiet_i,
                   full_listen: cfg_full_listen_i};
    assign terr = '{rise: err_rise_i, short_p: err_short_i, long_p: err_long_i};

    always_comb begin
        set_vec          = '0;
        set_vec[E_RISE]  = err_rise_i;
        set_vec[E_SHORT] = err_short_i;
        set_vec[E_LONG]  = err_long_i;
        set_vec[E_NOACK] = err_noack_i;
        set_vec[E_OVR]   = err_ovr_i;
    end

    cec_err_decide i_decide (
        .clk     (clk),
        .rst     (rst),
        .terr    (terr),
        .bcast   (frame_bcast_i),
        .cfg     (cfg),
        .stop_o  (rx_stop_o),
        .errbit_o(errbit_req_o)
    );

    cec_err_flags #(.N(NFLAG)) i_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (flag_clr_i),
        .flags_o(flags_o)
    );
endmodule

// File: rtl/cec_rx_err_policy_chk.sv
module cec_rx_err_policy_chk #(
    parameter int NFLAG = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             err_rise_i,
    input logic             err_short_i,
    input logic             err_long_i,
    input logic             err_noack_i,
    input logic             err_ovr_i,
    input logic             frame_bcast_i,
    input logic             cfg_stop_rise_i,
    input logic             cfg_gen_rise_i,
    input logic             cfg_gen_long_i,
    input logic             cfg_bcast_quiet_i,
    input logic             cfg_full_listen_i,
    input logic [NFLAG-1:0] flag_clr_i,
    input logic             rx_stop_o,
    input logic             errbit_req_o,
    input logic [NFLAG-1:0] flags_o
);
    assert_stop_rule_R2: assert property (@(posedge clk) disable iff (rst)
        !(err_rise_i && cfg_stop_rise_i) |=> !rx_stop_o);

    assert_stop_fires_R2: assert property (@(posedge clk) disable iff (rst)
        (err_rise_i && cfg_stop_rise_i) |=> rx_stop_o);

    assert_short_unicast_R5: assert property (@(posedge clk) disable iff (rst)
        (err_short_i && !frame_bcast_i) |=> errbit_req_o);

    assert_bcast_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_bcast_i && cfg_bcast_quiet_i && !err_short_i) |=> !errbit_req_o);

    assert_bcast_listen_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_bcast_i && cfg_full_listen_i && !err_rise_i && !err_long_i) |=> !errbit_req_o);

    assert_rise_flag_R10: assert property (@(posedge clk) disable iff (rst)
        err_rise_i |=> flags_o[0]);

    assert_noack_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i[3] && !err_noack_i) |=> !flags_o[3]);

    assert_pulse_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (!err_rise_i && !err_short_i && !err_long_i) |=> !errbit_req_o);
endmodule

bind cec_rx_err_policy cec_rx_err_policy_chk #(.NFLAG(NFLAG)) i_chk (.*);

// File: tb/test_cec_rx_err_policy.sv
`timescale 1ns/1ps
module test_cec_rx_err_policy;
    localparam int NF = 5;

    logic clk = 1'b0;
    logic rst;
    logic err_rise_i, err_short_i, err_long_i, err_noack_i, err_ovr_i;
    logic frame_bcast_i;
    logic cfg_stop_rise_i, cfg_gen_rise_i, cfg_gen_long_i, cfg_bcast_quiet_i, cfg_full_listen_i;
    logic [NF-1:0] flag_clr_i;
    logic rx_stop_o, errbit_req_o;
    logic [NF-1:0] flags_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cec_rx_err_policy i_cec_rx_err_policy (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_strobes();
        err_rise_i = 0; err_short_i = 0; err_long_i = 0;
        err_noack_i = 0; err_ovr_i = 0; flag_clr_i = '0;
    endtask

    // inputs applied just after a falling edge; outputs sampled at the next falling edge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(bit bc, bit r, bit s, bit l, bit q);
        if (!bc) return r ? "R3" : (l ? "R4" : "R5");
        if (q && !s) return "R8";
        return r ? "R6" : (l ? "R7" : "R9");
    endfunction

    initial begin
        rst = 1;
        idle_strobes();
        frame_bcast_i = 0;
        cfg_stop_rise_i = 0; cfg_gen_rise_i = 0; cfg_gen_long_i = 0;
        cfg_bcast_quiet_i = 0; cfg_full_listen_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 stop", {7'd0, rx_stop_o}, 8'd0);
        chk("R1 errbit", {7'd0, errbit_req_o}, 8'd0);
        chk("R1 flags", {3'd0, flags_o}, 8'd0);

        // full sweep: 5 cfg bits, broadcast, 3 timing errors
        for (int v = 0; v < 512; v++) begin
            bit sr, gr, gl, q, fl, bc, r, s, l, e_err, e_stop;
            {sr, gr, gl, q, fl, bc, r, s, l} = v[8:0];
            cfg_stop_rise_i = sr; cfg_gen_rise_i = gr; cfg_gen_long_i = gl;
            cfg_bcast_quiet_i = q; cfg_full_listen_i = fl; frame_bcast_i = bc;
            err_rise_i = r; err_short_i = s; err_long_i = l;
            if (bc)
                e_err = (r && sr && !q) || (l && !q) || (s && !fl);
            else
                e_err = (r && gr && sr) || s || (l && gl);
            e_stop = r && sr;
            cycle();
            idle_strobes();
            chk(tag_of(bc, r, s, l, q), {7'd0, errbit_req_o}, {7'd0, e_err});
            chk("R2", {7'd0, rx_stop_o}, {7'd0, e_stop});
            cycle();
            chk("R12 errbit pulse ends", {7'd0, errbit_req_o}, 8'd0);
            chk("R12 stop pulse ends", {7'd0, rx_stop_o}, 8'd0);
        end

        // flags: every timing flag set by the sweep; clear all, then one at a time
        chk("R10 timing flags after sweep", {3'd0, flags_o}, 8'h07);
        flag_clr_i = '1;
        cycle();
        idle_strobes();
        chk("R11 clear all", {3'd0, flags_o}, 8'h00);
        for (int k = 0; k < NF; k++) begin
            logic [NF-1:0] one;
            one = NF'(1) << k;
            {err_ovr_i, err_noack_i, err_long_i, err_short_i, err_rise_i} = one;
            cycle();
            idle_strobes();
            chk("R10 single flag", {3'd0, flags_o}, {3'd0, one});
            flag_clr_i = one;
            {err_ovr_i, err_noack_i, err_long_i, err_short_i, err_rise_i} = one;
            cycle();
            idle_strobes();
            chk("R11 set beats clear", {3'd0, flags_o}, {3'd0, one});
            flag_clr_i = ~one;
            cycle();
            idle_strobes();
            chk("R11 other clear bits no effect", {3'd0, flags_o}, {3'd0, one});
            flag_clr_i = one;
            cycle();
            idle_strobes();
            chk("R11 clear one", {3'd0, flags_o}, 8'h00);
        end

        // concurrent errors give a single request (R12)
        frame_bcast_i = 0; cfg_gen_long_i = 1; cfg_gen_rise_i = 1; cfg_stop_rise_i = 1;
        err_rise_i = 1; err_short_i = 1; err_long_i = 1;
        cycle();
        idle_strobes();
        chk("R12 combined request", {7'd0, errbit_req_o}, 8'd1);
        cycle();
        chk("R12 combined ends", {7'd0, errbit_req_o}, 8'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule